// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to the decode logic of a small 8-bit CPU core. It arbitrates five interrupt request lines. The top line is a non-maskable emergency line called TRAP. Below it are three vectored restart lines, RST7.5, RST6.5 and RST5.5. A general-purpose request line, INTR, comes last. The core marks each instruction boundary with a one-cycle strobe. In that cycle the block reports whether an interrupt is taken and which source won. For a vectored source it also gives the 16-bit vector address. For INTR it pulses an acknowledge strobe instead of giving a vector.

Software controls the block through four commands:
- Enable-interrupt sets a global enable. The enable takes effect only after the instruction that carried the command has completed.
- Disable-interrupt clears the global enable.
- Set-mask writes the three restart masks and can discard a latched RST7.5 edge.
- Read-mask is a combinational status byte. It carries the masks, the global enable, the pending state of the three restart lines and a serial-input data bit.

RST7.5 and TRAP are edge-captured. RST6.5, RST5.5 and INTR are plain levels.

Top module: `irq_arbiter`

## Requirements
- R1: At a boundary with several eligible requests, exactly one is taken. The order, highest first, is TRAP, RST7.5, RST6.5, RST5.5, INTR. The src_o codes are 0 none, 1 TRAP, 2 RST7.5, 3 RST6.5, 4 RST5.5 and 5 INTR.
- R2: A captured TRAP is taken at the next boundary whatever the global enable and the masks hold. Taking TRAP does not change the global enable.
- R3: TRAP becomes pending only on a rising edge of trap_in. The pending state is dropped if the line falls before a boundary samples it. A line that stays high after being taken does not request again.
- R4: A set-mask command with setmask_data[3]=1 loads the masks from setmask_data[2:0], where bit 0 masks RST5.5, bit 1 masks RST6.5 and bit 2 masks RST7.5. With setmask_data[3]=0 the masks are left unchanged. A masked restart line is never taken.
- R5: A rising edge on rst75_in is latched and stays pending after the line returns low. The latch is cleared when RST7.5 is taken, or by a set-mask command with setmask_data[4]=1. It latches while masked.
- R6: RST6.5 and RST5.5 are level requests and are not remembered. A pulse that ends before the block is able to take it is lost.
- R7: An enable command sets the global enable. The first boundary after the command cannot take a maskable request; later boundaries can. A disable command clears the enable.
- R8: Taking any maskable request (RST7.5, RST6.5, RST5.5 or INTR) clears the global enable.
- R9: The vectors are 0024h for TRAP, 003Ch for RST7.5, 0034h for RST6.5 and 002Ch for RST5.5. vector_o is 0000h when no vectored source is taken.
- R10: Taking INTR pulses inta_o for the boundary cycle, with vector_o at 0000h.
- R11: The read-mask byte maskrd_o holds the following fields. Bits [2:0] are the masks, laid out as in R4. Bit 3 is the global enable. Bits 4 and 5 are the live RST5.5 and RST6.5 line levels. Bit 6 is the RST7.5 pending latch. Bit 7 is sdi_in.
- R12: Reset clears the global enable, sets all three masks and clears both pending latches, so maskrd_o reads 07h with all inputs low. No maskable request is taken until an enable command is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_in | input | 1 | Non-maskable request line |
| rst75_in | input | 1 | Edge-captured restart request, second priority |
| rst65_in | input | 1 | Level restart request, third priority |
| rst55_in | input | 1 | Level restart request, fourth priority |
| intr_in | input | 1 | General-purpose level request, lowest priority |
| sdi_in | input | 1 | Serial input data bit reported in the read-mask byte |
| boundary_in | input | 1 | One-cycle strobe marking an instruction boundary |
| ei_cmd | input | 1 | Enable-interrupt command |
| di_cmd | input | 1 | Disable-interrupt command |
| setmask_cmd | input | 1 | Set-mask command strobe |
| setmask_data | input | 8 | Set-mask operand (bits [2:0] masks, 3 mask-load enable, 4 clear RST7.5 latch) |
| take_o | output | 1 | An interrupt is taken in this boundary cycle |
| src_o | output | 3 | Code of the source taken (0 if none) |
| vector_o | output | 16 | Vector address of the source taken |
| inta_o | output | 1 | Acknowledge strobe for a taken INTR |
| maskrd_o | output | 8 | Read-mask status byte |

## Verification
On every cycle the assertions check several properties. The grant is at most one-hot. A captured TRAP at a boundary always wins, however the enable and masks are set. The boundary just after an enable command never takes a maskable request. Any maskable take leaves the enable clear, and an acknowledge only happens while the enable is set. A cleared RST7.5 latch reads back empty. Other behaviour needs the bench's scenarios to show it. This covers the full priority ordering under different mask patterns and the per-source vectors. It also covers the effect of mask-load enable and latch clear, a TRAP line that stays high or falls before sampling, and a short RST5.5 pulse being lost.

// File: rtl/irq_pkg.sv
// Package: shared source codes, vector addresses and status-byte layout
// for the interrupt arbiter. Assumes index 0 of a request vector is the
// highest priority source.
package irq_pkg;
    localparam int N_SRC  = 5;
    localparam int VEC_W  = 16;
    localparam int SRC_W  = 3;
    localparam int MASK_W = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_INTR = 3'd5
    } src_t;

    // request vector positions, highest priority at 0
    localparam int IDX_TRAP = 0;
    localparam int IDX_R75  = 1;
    localparam int IDX_R65  = 2;
    localparam int IDX_R55  = 3;
    localparam int IDX_INTR = 4;

    // set-mask operand fields
    localparam int SM_LOAD  = 3;
    localparam int SM_CLR75 = 4;

    // mask bit positions
    localparam int M_R55 = 0;
    localparam int M_R65 = 1;
    localparam int M_R75 = 2;

    function automatic logic [VEC_W-1:0] vector_of(src_t s);
        case (s)
            SRC_TRAP: vector_of = 16'h0024;
            SRC_R75:  vector_of = 16'h003C;
            SRC_R65:  vector_of = 16'h0034;
            SRC_R55:  vector_of = 16'h002C;
            default:  vector_of = '0;
        endcase
    endfunction
endpackage

// File: rtl/irq_edge_latch.sv
// Edge-capture latch: goes pending on a rising edge of line_in and holds
// until clr_in. With DROP_ON_LOW set, a low line also discards the pending
// state (edge-and-level sensing). Assumes line_in is synchronous to clk.
module irq_edge_latch #(
    parameter bit DROP_ON_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic clr_in,
    output logic pend_o
);
    logic line_q;
    logic rise;

    assign rise = line_in & ~line_q;

    // remember the previous line level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_in;
    end

    generate
        if (DROP_ON_LOW) begin : g_edge_level
            // set on edge, clear on service or when the line drops
            always_ff @(posedge clk) begin
                if (!rst_n)              pend_o <= 1'b0;
                else if (rise)           pend_o <= 1'b1;
                else if (clr_in || !line_in) pend_o <= 1'b0;
            end
            assert_low_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !line_in |=> !pend_o);
        end else begin : g_edge_only
            // set on edge, clear only on explicit request
            always_ff @(posedge clk) begin
                if (!rst_n)      pend_o <= 1'b0;
                else if (rise)   pend_o <= 1'b1;
                else if (clr_in) pend_o <= 1'b0;
            end
        end
    endgenerate

    assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in && !rise) |=> !pend_o);
endmodule

// File: rtl/irq_ctrl_regs.sv
// Control state: global enable, its one-boundary deferral after an enable
// command, and the restart mask register. Assumes commands are single-cycle
// strobes and that enable and disable never arrive together.
module irq_ctrl_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ei_cmd,
    input  logic              di_cmd,
    input  logic              setmask_cmd,
    input  logic [7:0]        setmask_data,
    input  logic              boundary_in,
    input  logic              took_maskable,
    output logic              ie_o,
    output logic              en_now_o,
    output logic [MASK_W-1:0] mask_o
);
    logic defer_q;

    assign en_now_o = ie_o & ~defer_q;

    // mask register load through set-mask with its load bit set
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '1;
        else if (setmask_cmd && setmask_data[SM_LOAD])
            mask_o <= setmask_data[MASK_W-1:0];
    end

    // global enable and deferral window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_o    <= 1'b0;
            defer_q <= 1'b0;
        end else if (ei_cmd) begin
            ie_o    <= 1'b1;
            defer_q <= 1'b1;
        end else if (di_cmd) begin
            ie_o    <= 1'b0;
            defer_q <= 1'b0;
        end else begin
            if (took_maskable) ie_o    <= 1'b0;
            if (boundary_in)   defer_q <= 1'b0;
        end
    end

    assert_take_clears_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (took_maskable && !ei_cmd) |=> !ie_o);
endmodule

// File: rtl/irq_prio_sel.sv
// Fixed-priority selector: grants the lowest-index active request and
// reports its index. Assumes index 0 is the most urgent request.
module irq_prio_sel #(
    parameter int N = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_grant
            if (gi == 0) begin : g_top
                assign grant_o[gi] = req_i[gi];
            end else begin : g_rest
                assign grant_o[gi] = req_i[gi] & ~|req_i[gi-1:0];
            end
        end
    endgenerate

    assign any_o = |req_i;

    // encode the granted position
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++)
            if (grant_o[i]) idx_o = IW'(i);
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    assert_grant_when_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> (|grant_o));
endmodule

// File: rtl/irq_arbiter.sv
// Top: five-line prioritized vectored interrupt arbiter. Builds the eligible
// request set from the pending latches, live levels, enable and masks. It
// resolves the set at each boundary strobe and drives the source code, the
// vector or the acknowledge. Assumes all inputs are synchronous to clk and
// that the boundary strobe lasts one cycle.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_in,
    input  logic             rst75_in,
    input  logic             rst65_in,
    input  logic             rst55_in,
    input  logic             intr_in,
    input  logic             sdi_in,
    input  logic             boundary_in,
    input  logic             ei_cmd,
    input  logic             di_cmd,
    input  logic             setmask_cmd,
    input  logic [7:0]       setmask_data,
    output logic             take_o,
    output logic [SRC_W-1:0] src_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             inta_o,
    output logic [7:0]       maskrd_o
);
    localparam int IW = $clog2(N_SRC);

    logic              trap_pend, r75_pend;
    logic              ie, en_now;
    logic [MASK_W-1:0] mask;
    logic [N_SRC-1:0]  req, grant;
    logic              any;
    logic [IW-1:0]     idx;
    src_t              src;
    logic              took_trap, took_r75, took_maskable, clr75;

    assign clr75 = took_r75 | (setmask_cmd & setmask_data[SM_CLR75]);

    irq_edge_latch #(.DROP_ON_LOW(1'b1)) u_trap_latch (
        .clk(clk), .rst_n(rst_n), .line_in(trap_in),
        .clr_in(took_trap), .pend_o(trap_pend)
    );

    irq_edge_latch #(.DROP_ON_LOW(1'b0)) u_r75_latch (
        .clk(clk), .rst_n(rst_n), .line_in(rst75_in),
        .clr_in(clr75), .pend_o(r75_pend)
    );

    irq_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .setmask_cmd(setmask_cmd), .setmask_data(setmask_data),
        .boundary_in(boundary_in), .took_maskable(took_maskable),
        .ie_o(ie), .en_now_o(en_now), .mask_o(mask)
    );

    // eligible requests, qualified by the boundary strobe
    always_comb begin
        req           = '0;
        req[IDX_TRAP] = trap_pend & trap_in;
        req[IDX_R75]  = en_now & ~mask[M_R75] & r75_pend;
        req[IDX_R65]  = en_now & ~mask[M_R65] & rst65_in;
        req[IDX_R55]  = en_now & ~mask[M_R55] & rst55_in;
        req[IDX_INTR] = en_now & intr_in;
        if (!boundary_in) req = '0;
    end

    irq_prio_sel #(.N(N_SRC)) u_sel (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .grant_o(grant), .any_o(any), .idx_o(idx)
    );

    // map the granted index to a source code
    always_comb begin
        if (any) src = src_t'(SRC_W'(idx) + SRC_W'(1));
        else     src = SRC_NONE;
    end

    assign took_trap     = grant[IDX_TRAP];
    assign took_r75      = grant[IDX_R75];
    assign took_maskable = |grant[N_SRC-1:IDX_R75];

    assign take_o   = any;
    assign src_o    = src;
    assign vector_o = vector_of(src);
    assign inta_o   = grant[IDX_INTR];

    // read-mask status byte
    assign maskrd_o = {sdi_in, r75_pend, rst65_in, rst55_in, ie, mask};

    assert_trap_unmaskable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_in && trap_pend && trap_in) |-> (take_o && src_o == SRC_TRAP));
    assert_ei_deferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ei_cmd |=> !(take_o && src_o != SRC_TRAP));
    assert_inta_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |-> (intr_in && maskrd_o[3] && vector_o == '0));
endmodule

// File: tb/irq_arbiter_bench.sv
// Self-checking bench: a vector table for the level lines under mask
// patterns, then directed tests for reset, edges, enable timing and status.
module irq_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, intr_in = 0;
    logic        sdi_in = 0, boundary_in = 0, ei_cmd = 0, di_cmd = 0, setmask_cmd = 0;
    logic [7:0]  setmask_data = '0;
    logic        take_o, inta_o;
    logic [2:0]  src_o;
    logic [15:0] vector_o;
    logic [7:0]  maskrd_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic        s_take, s_inta;
    logic [2:0]  s_src;
    logic [15:0] s_vec;

    always #5 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rst75_in(rst75_in),
        .rst65_in(rst65_in), .rst55_in(rst55_in), .intr_in(intr_in),
        .sdi_in(sdi_in), .boundary_in(boundary_in), .ei_cmd(ei_cmd),
        .di_cmd(di_cmd), .setmask_cmd(setmask_cmd), .setmask_data(setmask_data),
        .take_o(take_o), .src_o(src_o), .vector_o(vector_o), .inta_o(inta_o),
        .maskrd_o(maskrd_o)
    );

    // table: {mask[2:0] (m75,m65,m55), levels {r65,r55,intr}, src, vector}
    localparam logic [24:0] TBL [8] = '{
        {3'b000, 3'b111, 3'd3, 16'h0034},
        {3'b000, 3'b011, 3'd4, 16'h002C},
        {3'b000, 3'b001, 3'd5, 16'h0000},
        {3'b010, 3'b111, 3'd4, 16'h002C},
        {3'b011, 3'b111, 3'd5, 16'h0000},
        {3'b011, 3'b110, 3'd0, 16'h0000},
        {3'b001, 3'b101, 3'd3, 16'h0034},
        {3'b111, 3'b000, 3'd0, 16'h0000}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc();
        @(posedge clk); #1;
    endtask

    task automatic cmd_setmask(logic [7:0] d);
        @(negedge clk); setmask_cmd = 1; setmask_data = d;
        @(posedge clk); #1; setmask_cmd = 0; setmask_data = '0;
    endtask

    task automatic cmd_ei();
        @(negedge clk); ei_cmd = 1;
        @(posedge clk); #1; ei_cmd = 0;
    endtask

    task automatic cmd_di();
        @(negedge clk); di_cmd = 1;
        @(posedge clk); #1; di_cmd = 0;
    endtask

    // one boundary strobe; outputs captured mid-cycle
    task automatic bnd();
        @(negedge clk); boundary_in = 1; #1;
        s_take = take_o; s_src = src_o; s_vec = vector_o; s_inta = inta_o;
        @(posedge clk); #1; boundary_in = 0;
    endtask

    task automatic rd_check(string req, logic [7:0] exp);
        @(negedge clk); #1;
        check(req, maskrd_o, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        intr_in = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R12: reset state
        rd_check("R12 reset status", 8'h07);
        bnd();
        check("R12 no take while disabled", {s_take, s_inta}, 2'b00);
        intr_in = 0;

        // R11: serial bit position
        sdi_in = 1;
        rd_check("R11 sdi bit7", 8'h87);
        sdi_in = 0;

        // R4: load enable gating
        cmd_setmask(8'h00);
        rd_check("R4 masks kept without load bit", 8'h07);
        cmd_setmask(8'h08);
        rd_check("R4 masks loaded", 8'h00);

        // table walk: R1 priority among level lines, R4 masks, R9 vectors
        for (int i = 0; i < 8; i++) begin
            cmd_setmask({5'b00001, TBL[i][24:22]});
            cmd_ei();
            bnd();
            check("R7 deferred boundary in table", s_take, 1'b0);
            {rst65_in, rst55_in, intr_in} = TBL[i][21:19];
            bnd();
            check("R1 table source", s_src, TBL[i][18:16]);
            check("R9 table vector", s_vec, TBL[i][15:0]);
            check("R10 table acknowledge", s_inta, TBL[i][18:16] == 3'd5);
            {rst65_in, rst55_in, intr_in} = 3'b000;
            if (TBL[i][18:16] != 3'd0) begin
                @(negedge clk); #1;
                check("R8 enable cleared after take", maskrd_o[3], 1'b0);
            end
        end

        // R7: disable then deferred enable
        cmd_di();
        intr_in = 1;
        bnd();
        check("R7 disabled blocks INTR", s_take, 1'b0);
        cmd_ei();
        bnd();
        check("R7 first boundary after enable", s_take, 1'b0);
        bnd();
        check("R10 INTR taken with acknowledge", {s_take, s_src, s_inta, s_vec}, {1'b1, 3'd5, 1'b1, 16'h0000});
        intr_in = 0;

        // R2/R3: TRAP with enable off and all masks set
        trap_in = 1;
        wait_cyc();
        bnd();
        check("R2 TRAP taken while disabled", {s_take, s_src}, {1'b1, 3'd1});
        check("R9 TRAP vector", s_vec, 16'h0024);
        bnd();
        check("R3 stuck-high TRAP no retrigger", s_take, 1'b0);
        trap_in = 0; wait_cyc();
        trap_in = 1; wait_cyc();
        trap_in = 0; wait_cyc();
        bnd();
        check("R3 TRAP dropped before sampling", s_take, 1'b0);

        // R5: RST7.5 latch and clear
        rst75_in = 1; wait_cyc(); rst75_in = 0; wait_cyc();
        rd_check("R5 latched while masked", 8'h47);
        cmd_setmask(8'h10);
        rd_check("R5 cleared by set-mask", 8'h07);
        rst75_in = 1; wait_cyc(); rst75_in = 0; wait_cyc();
        cmd_setmask(8'h08);
        rd_check("R5 latch kept across mask load", 8'h40);
        cmd_ei();
        rd_check("R11 enable bit", 8'h48);
        bnd();
        check("R7 deferral with RST7.5 pending", s_take, 1'b0);
        bnd();
        check("R5 RST7.5 taken", {s_take, s_src, s_vec}, {1'b1, 3'd2, 16'h003C});
        rd_check("R5 latch cleared on take", 8'h00);

        // R1: TRAP beats RST7.5, which follows at the next boundary
        cmd_ei();
        bnd();
        rst75_in = 1; trap_in = 1; wait_cyc(); rst75_in = 0; wait_cyc();
        bnd();
        check("R1 TRAP over RST7.5", s_src, 3'd1);
        bnd();
        check("R2 enable kept after TRAP, RST7.5 next", s_src, 3'd2);
        trap_in = 0;

        // R6: level pulse is not remembered
        rst55_in = 1;
        rd_check("R11 live RST5.5 level", 8'h10);
        rst55_in = 0;
        cmd_ei();
        bnd();
        bnd();
        check("R6 RST5.5 pulse lost", s_take, 1'b0);
        rst65_in = 1;
        rd_check("R11 live RST6.5 level", 8'h28);
        rst65_in = 0;

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule